// File: doc/BRIEF.md
# Serial ADC Lane Deserializer With Frame Alignment

This block sits behind the input capture of a multi-lane serial ADC link and turns each lane's bit stream back into 12-bit parallel samples. Every cycle of the bit clock it takes two recovered bits per lane, one from each clock edge, so one sample takes six cycles. A frame clock running at the sample rate is sampled in the same clock domain, and its rising edge marks the cycle that carries the first two bits of a new word. All lanes share this frame timing.

A slip input moves the word boundary one bit at a time so that a receiver can correct a frame clock that is out of step with the data. A bit-order input matches the transmitter's choice of sending the least or the most significant bit first. In a sync-check mode, each lane compares its words with the six-zeros-then-six-ones training word and reports lock. In a deskew-check mode, it flags any word that is not an alternating bit pattern, which confirms that the bit capture point is correct.

Top module: `adc_lane_deserializer`

## Requirements
- R1: During and after a synchronous active-high reset, all words, the valid strobe, the lock flags and the deskew flags read zero.
- R2: Lane l supplies its first-received bit of a cycle on lane_bits_i[2l] and the second bit on lane_bits_i[2l+1]. Bit i of a word is its i-th received bit. The word whose first bits arrive in the cycle of a frame-clock rising edge appears on word_o in the cycle after the second frame edge that follows, together with a one-cycle valid_o pulse. This is one pulse per frame, and none before two frames have passed.
- R3: With msb_first_i low, the first received bit is bit 0 of the output word. With msb_first_i high, the word is bit-reversed, so the first received bit is bit 11.
- R4: Each cycle with slip_i high moves the word boundary one bit earlier in the stream, modulo 12. After k slips, a word holds the last k bits of the previous frame followed by the first 12-k bits of the current frame.
- R5: Every lane is reassembled independently into its own 12-bit field, word_o[12l+11:12l].
- R6: In sync-check mode (mode_i = 1), a lane's lock flag rises on the fourth consecutive output word that equals the training word. In received order the training word is six 0 bits followed by six 1 bits (0xFC0 in least-significant-first order). The flag does not rise after three matches.
- R7: In sync-check mode, a single mismatching word leaves a set lock flag set. Two consecutive mismatches clear it.
- R8: In any mode other than sync-check, the lock flags keep their value, whatever the data.
- R9: In deskew-check mode (mode_i = 2), a lane's deskew flag is set for a word that is neither 0x555 nor 0xAAA and cleared for a word that is either. In any other mode the flags read zero.
- R10: word_o and locked_o change only in cycles where valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per two bits |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk_i | input | 1 | Sample-rate frame clock, rising edge marks first bits of a word |
| lane_bits_i | input | LANES*2 | Two received bits per lane per cycle |
| slip_i | input | 1 | Each high cycle moves the word boundary one bit earlier |
| msb_first_i | input | 1 | Reassemble with the first received bit as most significant |
| mode_i | input | 2 | 0 pass, 1 sync check, 2 deskew check |
| word_o | output | LANES*12 | Parallel words, lane l in bits 12l+11:12l |
| valid_o | output | 1 | One-cycle pulse when new words are presented |
| locked_o | output | LANES | Per-lane frame alignment lock |
| deskew_err_o | output | LANES | Per-lane non-alternating word flag |

## Verification
Words that are asymmetric, such as 0x123 and 0xA5C, separate the least- and most-significant-first orderings. Single set bits and edge-heavy words (0x001, 0x801, 0x0F0), repeated across frames under several slip counts, show whether the boundary moves in the right direction and wraps at twelve. Distinct words on each lane expose any crossing between lanes. Runs of the training word broken by one or two bad frames test the lock threshold and the unlock hysteresis, and a lone corrupted lane among alternating words shows that the deskew flag is kept per lane.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  typedef enum logic [1:0] {
    CHK_PASS   = 2'd0,
    CHK_SYNC   = 2'd1,
    CHK_DESKEW = 2'd2
  } chk_mode_e;
endpackage

// File: rtl/adc_deser_frame_timer.sv
module adc_deser_frame_timer #(
  parameter int WORD_W = 12,
  localparam int SLIP_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_clk_i,
  input  logic              slip_i,
  output logic              frame_edge_o,
  output logic [SLIP_W-1:0] slip_off_o,
  output logic              primed_o
);
  logic frm_q;

  // rising edge of the sampled frame clock: cycle carrying a word's first bits
  assign frame_edge_o = frame_clk_i & ~frm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q      <= 1'b0;
      slip_off_o <= '0;
      primed_o   <= 1'b0;
    end else begin
      frm_q <= frame_clk_i;
      if (frame_edge_o) primed_o <= 1'b1;
      if (slip_i) begin
        if (slip_off_o == SLIP_W'(WORD_W - 1)) slip_off_o <= '0;
        else                                   slip_off_o <= slip_off_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_deser_lane_capture.sv
module adc_deser_lane_capture #(
  parameter int WORD_W = 12,
  parameter int BPC    = 2,
  localparam int SLIP_W = $clog2(WORD_W),
  localparam int HQ     = 2 * WORD_W,
  localparam int HW     = HQ + BPC,
  localparam int SHW    = $clog2(HW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BPC-1:0]    bits_i,
  input  logic              frame_edge_i,
  input  logic              load_out_i,
  input  logic [SLIP_W-1:0] slip_off_i,
  input  logic              msb_first_i,
  output logic [WORD_W-1:0] raw_o,
  output logic [WORD_W-1:0] word_o
);
  logic [HQ-1:0]     hist_q;
  logic [HW-1:0]     hist_next;
  logic [SHW-1:0]    base;
  logic [WORD_W-1:0] window;
  logic [WORD_W-1:0] reversed;

  // newest bits enter at the top; the later bit of a cycle sits highest
  assign hist_next = {bits_i, hist_q};
  // in the edge cycle the previous word starts at index WORD_W; slips move it earlier
  assign base      = SHW'(WORD_W) - SHW'(slip_off_i);
  assign window    = hist_next[base +: WORD_W];

  always_comb begin
    for (int i = 0; i < WORD_W; i++) reversed[i] = raw_o[WORD_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      raw_o  <= '0;
      word_o <= '0;
    end else begin
      hist_q <= hist_next[HW-1:BPC];
      if (frame_edge_i) raw_o  <= window;
      if (load_out_i)   word_o <= msb_first_i ? reversed : raw_o;
    end
  end
endmodule

// File: rtl/adc_deser_lane_monitor.sv
module adc_deser_lane_monitor
  import adc_deser_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int LOCK_N   = 4,
  parameter int UNLOCK_N = 2,
  localparam int CW = $clog2(LOCK_N + 1),
  localparam int MW = $clog2(UNLOCK_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic              locked_o,
  output logic              deskew_err_o
);
  logic [WORD_W-1:0] sync_pat;
  logic [WORD_W-1:0] alt_pat;
  logic [CW-1:0]     match_cnt;
  logic [MW-1:0]     miss_cnt;
  logic              sync_hit;
  logic              alt_hit;

  // patterns in received order: bit i is the i-th bit on the wire
  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      sync_pat[i] = (i >= WORD_W / 2);
      alt_pat[i]  = ((i % 2) != 0);
    end
  end

  assign sync_hit = (raw_i == sync_pat);
  assign alt_hit  = (raw_i == alt_pat) || (raw_i == ~alt_pat);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_cnt    <= '0;
      miss_cnt     <= '0;
      locked_o     <= 1'b0;
      deskew_err_o <= 1'b0;
    end else begin
      if (mode_i != CHK_DESKEW)  deskew_err_o <= 1'b0;
      else if (chk_en_i)         deskew_err_o <= ~alt_hit;

      if (chk_en_i && mode_i == CHK_SYNC) begin
        if (sync_hit) begin
          miss_cnt <= '0;
          if (match_cnt >= CW'(LOCK_N - 1)) locked_o  <= 1'b1;
          if (match_cnt != CW'(LOCK_N))     match_cnt <= match_cnt + 1'b1;
        end else begin
          match_cnt <= '0;
          if (miss_cnt >= MW'(UNLOCK_N - 1)) locked_o <= 1'b0;
          if (miss_cnt != MW'(UNLOCK_N))     miss_cnt <= miss_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_lane_deserializer.sv
module adc_lane_deserializer #(
  parameter int LANES    = 8,
  parameter int WORD_W   = 12,
  parameter int BPC      = 2,
  parameter int LOCK_N   = 4,
  parameter int UNLOCK_N = 2,
  localparam int SLIP_W  = $clog2(WORD_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_clk_i,
  input  logic [LANES*BPC-1:0]    lane_bits_i,
  input  logic                    slip_i,
  input  logic                    msb_first_i,
  input  logic [1:0]              mode_i,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic                    valid_o,
  output logic [LANES-1:0]        locked_o,
  output logic [LANES-1:0]        deskew_err_o
);
  logic              frame_edge;
  logic [SLIP_W-1:0] slip_off;
  logic              primed;
  logic              stage_vld;
  logic              load_out;

  adc_deser_frame_timer #(.WORD_W(WORD_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .frame_clk_i  (frame_clk_i),
    .slip_i       (slip_i),
    .frame_edge_o (frame_edge),
    .slip_off_o   (slip_off),
    .primed_o     (primed)
  );

  assign load_out = frame_edge & stage_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_vld <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      if (frame_edge) stage_vld <= primed;
      valid_o <= load_out;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] raw;

    adc_deser_lane_capture #(.WORD_W(WORD_W), .BPC(BPC)) u_cap (
      .clk          (clk),
      .rst          (rst),
      .bits_i       (lane_bits_i[l*BPC +: BPC]),
      .frame_edge_i (frame_edge),
      .load_out_i   (load_out),
      .slip_off_i   (slip_off),
      .msb_first_i  (msb_first_i),
      .raw_o        (raw),
      .word_o       (word_o[l*WORD_W +: WORD_W])
    );

    adc_deser_lane_monitor #(.WORD_W(WORD_W), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .chk_en_i     (load_out),
      .mode_i       (mode_i),
      .raw_i        (raw),
      .locked_o     (locked_o[l]),
      .deskew_err_o (deskew_err_o[l])
    );
  end
endmodule

// File: rtl/adc_deser_checker.sv
module adc_deser_checker
  import adc_deser_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int WORD_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              mode_i,
  input logic [LANES*WORD_W-1:0] word_o,
  input logic                    valid_o,
  input logic [LANES-1:0]        locked_o,
  input logic [LANES-1:0]        deskew_err_o
);
  // R2: a frame spans several cycles, so the strobe never lasts two
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R10: words only move with the strobe
  assert_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o));

  // R10: lock flags only move with the strobe
  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(locked_o));

  // R6 / R8: a lock flag rises only on a word judged in sync-check mode
  assert_lock_rise_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (|(locked_o & ~$past(locked_o))) |-> (valid_o && $past(mode_i) == CHK_SYNC));

  // R9: deskew flags are clear outside deskew-check mode
  assert_deskew_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) != CHK_DESKEW) |-> (deskew_err_o == '0));
endmodule

bind adc_lane_deserializer adc_deser_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .word_o       (word_o),
  .valid_o      (valid_o),
  .locked_o     (locked_o),
  .deskew_err_o (deskew_err_o)
);

// File: tb/adc_lane_deserializer_test.sv
module adc_lane_deserializer_test;
  import adc_deser_pkg::*;

  localparam int L   = 8;
  localparam int W   = 12;
  localparam int FRM = 6;
  localparam int NV  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_clk = 1'b0;
  logic [L*2-1:0]   lane_bits = '0;
  logic             slip = 1'b0;
  logic             msb_first = 1'b0;
  logic [1:0]       mode = CHK_PASS;
  logic [L*W-1:0]   word;
  logic             valid;
  logic [L-1:0]     locked;
  logic [L-1:0]     deskew_err;

  int checks = 0;
  int errors = 0;
  int slip_left = 0;
  int stray_vld = 0;
  int vld_cnt = 0;
  int frames_run = 0;
  logic [L*W-1:0] obs_word;
  logic           obs_valid;
  logic [L-1:0]   obs_locked;
  logic [L-1:0]   obs_err;

  always #5 clk = ~clk;

  adc_lane_deserializer #(.LANES(L), .WORD_W(W)) uut (
    .clk          (clk),
    .rst          (rst),
    .frame_clk_i  (frame_clk),
    .lane_bits_i  (lane_bits),
    .slip_i       (slip),
    .msb_first_i  (msb_first),
    .mode_i       (mode),
    .word_o       (word),
    .valid_o      (valid),
    .locked_o     (locked),
    .deskew_err_o (deskew_err)
  );

  // {sent word (bit i = i-th received), msb_first, slips added, expected output}
  localparam logic [28:0] VEC [NV] = '{
    {12'h123, 1'b0, 4'd0, 12'h123},  // R3 lsb first
    {12'hA5C, 1'b1, 4'd0, 12'h3A5},  // R3 msb first reverses
    {12'h001, 1'b0, 4'd1, 12'h002},  // R4 one slip
    {12'h801, 1'b0, 4'd2, 12'h00C},  // R4 three slips in total
    {12'h0F0, 1'b1, 4'd0, 12'h01E},  // R3 with R4 combined
    {12'hFFF, 1'b0, 4'd9, 12'hFFF},  // R4 twelve slips wrap to zero
    {12'h5A5, 1'b0, 4'd0, 12'h5A5},  // R4 boundary back at zero
    {12'hFC0, 1'b1, 4'd0, 12'h03F}   // R3 training word reversed
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L*W-1:0] all_lanes(input logic [W-1:0] v);
    return {L{v}};
  endfunction

  // send one frame; outputs are snapshotted in the cycle after the frame edge
  task automatic run_frame(input logic [L*W-1:0] w);
    for (int ph = 0; ph < FRM; ph++) begin
      @(negedge clk);
      if (ph == 1) begin
        obs_word = word; obs_valid = valid; obs_locked = locked; obs_err = deskew_err;
        if (valid) vld_cnt++;
      end else if (valid) begin
        stray_vld++;
      end
      frame_clk = (ph < FRM / 2);
      slip = (slip_left > 0);
      if (slip_left > 0) slip_left--;
      for (int l = 0; l < L; l++) begin
        lane_bits[l*2]   = w[l*W + 2*ph];
        lane_bits[l*2+1] = w[l*W + 2*ph + 1];
      end
    end
    frames_run++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [L*W-1:0] wa, wb, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(word == '0 && !valid && locked == '0 && deskew_err == '0, "R1 reset outputs",
        {word, valid, locked, deskew_err}, '0);

    // R2: latency and first valid
    run_frame(all_lanes(12'h3C5));
    chk(!obs_valid, "R2 no valid after one frame", obs_valid, 0);
    run_frame('0);
    chk(!obs_valid, "R2 no valid after two frames", obs_valid, 0);
    run_frame('0);
    chk(obs_valid && obs_word == all_lanes(12'h3C5), "R2 first word", obs_word, all_lanes(12'h3C5));

    // R3 / R4 vector table
    for (int r = 0; r < NV; r++) begin
      logic [W-1:0] tw, te;
      tw = VEC[r][28:17];
      te = VEC[r][11:0];
      msb_first = VEC[r][16];
      slip_left = int'(VEC[r][15:12]);
      repeat (4) run_frame(all_lanes(tw));
      chk(obs_valid && obs_word == all_lanes(te), $sformatf("R3 R4 table row %0d", r),
          obs_word, all_lanes(te));
    end
    msb_first = 1'b0;

    // R5: distinct words per lane
    for (int l = 0; l < L; l++) wa[l*W +: W] = W'(12'h300 + (l + 1) * 37);
    wb = ~wa;
    run_frame(wa);
    run_frame(wb);
    run_frame(wa ^ all_lanes(12'h0F0));
    for (int l = 0; l < L; l++)
      chk(obs_word[l*W +: W] == wa[l*W +: W], $sformatf("R5 lane %0d", l),
          obs_word[l*W +: W], wa[l*W +: W]);

    // R6: lock needs four matches
    mode = CHK_SYNC;
    run_frame('0); run_frame('0);
    repeat (5) run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '0, "R6 not locked after three matches", obs_locked, '0);
    run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '1, "R6 locked after four matches", obs_locked, '1);

    // R7: one miss tolerated, two clear
    run_frame('0);
    run_frame(all_lanes(12'hFC0)); run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '1, "R7 single mismatch keeps lock", obs_locked, '1);
    run_frame(all_lanes(12'hFC0)); run_frame(all_lanes(12'hFC0));
    run_frame('0); run_frame('0);
    run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '1, "R7 lock held after first of two misses", obs_locked, '1);
    run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '0, "R7 two mismatches clear lock", obs_locked, '0);

    // R8: lock ignores data outside sync-check mode
    repeat (6) run_frame(all_lanes(12'hFC0));
    chk(obs_locked == '1, "R6 relock", obs_locked, '1);
    mode = CHK_PASS;
    repeat (4) run_frame('0);
    chk(obs_locked == '1, "R8 lock kept in pass mode", obs_locked, '1);

    // R9: deskew flags per lane
    mode = CHK_DESKEW;
    repeat (3) run_frame(all_lanes(12'h555));
    chk(obs_err == '0, "R9 alternating 0x555 accepted", obs_err, '0);
    bad = all_lanes(12'hAAA);
    bad[3*W +: W] = 12'h554;
    run_frame(bad);
    run_frame(all_lanes(12'hAAA));
    run_frame(all_lanes(12'hAAA));
    chk(obs_err == L'(8'b0000_1000), "R9 lane 3 flagged", obs_err, L'(8'b0000_1000));
    run_frame(all_lanes(12'hAAA));
    chk(obs_err == '0, "R9 alternating 0xAAA accepted", obs_err, '0);
    mode = CHK_PASS;
    run_frame(bad);
    run_frame(all_lanes(12'hAAA));
    run_frame(all_lanes(12'hAAA));
    chk(obs_err == '0, "R9 flags clear in pass mode", obs_err, '0);
    chk(obs_locked == '1, "R8 lock kept through deskew mode", obs_locked, '1);

    // R2: one strobe per frame, only in the cycle after the edge
    chk(stray_vld == 0, "R2 strobe timing", stray_vld, 0);
    chk(vld_cnt == frames_run - 2, "R2 one strobe per frame", vld_cnt, frames_run - 2);

    // R1: reset from a busy state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(word == '0 && !valid && locked == '0 && deskew_err == '0, "R1 reset mid-run",
        {word, valid, locked, deskew_err}, '0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule